// File: doc/BRIEF.md
# ULPI PHY Register Access Engine

This block is the link-side sequencer that carries out one PHY register read or write at a time over the ULPI bus. It runs in the 60 MHz ULPI clock domain. A request is made with a one-cycle start strobe that carries a read/write select, an eight-bit register address and, for writes, a data byte. The engine then drives the command byte, an optional extended address byte and the data byte, each held until the PHY takes it with NXT. For a read, it passes through the two DIR turnaround cycles and captures the returned byte in between. When the transaction ends it raises a done flag, and that flag stays up until the next accepted request.

The requested address picks the access type. Addresses below the extended threshold (parameter `EXT_BASE`, default 0x2F) use immediate access. Addresses at or above it send a marker in the command byte and then the full address in a second byte. With a PHY that answers at once, the access type fixes the transaction length exactly: 5 cycles for an immediate write, 6 for an immediate read or an extended write, and 7 for an extended read. These counts run from the clock edge that accepts the start strobe to the first cycle in which done is high. If the PHY raises DIR before it has taken the command byte, receive traffic has priority: the engine drops the bus and re-issues the command once DIR falls. A watchdog stops any transaction that has not finished after `wd_limit` cycles and reports it with an error flag beside done.

The FSM states are Idle, Load, Command, ExtAddr, WriteData, Stop, Turn1, ReadData, Turn2 and Finish. The transitions are as follows:
- Idle goes to Load on an accepted start.
- Load waits while DIR is high, then goes to Command.
- Command goes back to Load on DIR (abort and retry). On NXT it goes to ExtAddr for extended access, to WriteData for an immediate write, or to Turn1 for an immediate read.
- ExtAddr goes on NXT to WriteData or Turn1.
- WriteData goes on NXT to Stop.
- Stop goes to Finish.
- Turn1 waits for DIR high, then goes to ReadData.
- ReadData goes to Turn2, and Turn2 goes to Finish.
- Finish goes to Idle and sets done.
- Watchdog expiry sends any state to Idle.

Top module: `ulpi_regacc_engine`

## Requirements
- R1: After reset, acc_done, acc_err, ulpi_stp and ulpi_dout_en are all low.
- R2: The command byte holds the operation in bits [7:6], 2'b10 for a write and 2'b11 for a read. For an address below EXT_BASE (0x2F), bits [5:0] hold the address. For an address at or above it, bits [5:0] hold the marker 6'h2F and the next byte holds the full eight-bit address.
- R3: An immediate write with a PHY that takes every byte at once raises acc_done exactly 5 cycles after the start edge. It delivers the data byte and asserts ulpi_stp for exactly one cycle after that byte, in cycle 3.
- R4: An extended write under the same conditions raises acc_done exactly 6 cycles after the start edge.
- R5: An immediate read raises acc_done exactly 6 cycles after the start edge. rd_data then equals the byte the PHY drove in the one cycle between the two DIR turnaround cycles.
- R6: An extended read raises acc_done exactly 7 cycles after the start edge and returns the addressed register's byte.
- R7: Each outgoing byte after the command stays unchanged on ulpi_dout until ulpi_nxt takes it. Every stalled cycle lengthens the transaction by one cycle.
- R8: If ulpi_dir rises before the command byte is taken, the engine releases the data bus (ulpi_dout_en low) while DIR is high. It re-issues the command after DIR falls and completes the original request.
- R9: A transaction still unfinished wd_limit cycles after the start edge ends in that cycle with acc_done and acc_err both high, and no write reaches the PHY.
- R10: A start strobe that arrives while a transaction is in progress is ignored: the running transaction keeps its timing and the other address is not written.
- R11: An accepted start clears acc_done and acc_err in the next cycle. acc_done then stays high from completion until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz ULPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle new-request strobe; honoured only when idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | AW | PHY register address |
| req_wdata | input | 8 | Data byte for writes |
| wd_limit | input | TO_W | Watchdog cycle limit, held stable during a transaction |
| rd_data | output | 8 | Byte returned by the last read |
| acc_done | output | 1 | Transaction finished (pollable level) |
| acc_err | output | 1 | Transaction ended by the watchdog |
| ulpi_dir | input | 1 | PHY bus direction |
| ulpi_nxt | input | 1 | PHY byte acknowledge |
| ulpi_din | input | 8 | ULPI data from the PHY |
| ulpi_dout | output | 8 | ULPI data from the link |
| ulpi_dout_en | output | 1 | Link drives the ULPI data lines |
| ulpi_stp | output | 1 | ULPI stop |

## Verification
The bench runs immediate and extended reads and writes with a PHY model that takes bytes at once. The address pair 0x2E/0x2F separates the two access types by cycle count and by command byte, and a per-cycle reference model predicts done, drive-enable and STP. Data values 0x00 and 0xFF, written and then read back through the PHY model's register store, show that the capture in the turnaround window is correct and does not just echo the last driven byte. NXT stalls, DIR arriving ahead of command acceptance, and a PHY that never answers each give different timing, which separates hold-until-NXT, abort-and-retry and watchdog expiry. A start strobe injected mid-transaction shows that a busy engine ignores it.

// File: rtl/ulpi_regacc_pkg.sv
`timescale 1ns/1ps
package ulpi_regacc_pkg;

    localparam int ULPI_DW = 8;

    localparam logic [1:0] OP_REG_WRITE = 2'b10;
    localparam logic [1:0] OP_REG_READ  = 2'b11;
    localparam logic [5:0] EXT_MARKER   = 6'h2F;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_CMD,
        S_EADDR,
        S_WDATA,
        S_STOP,
        S_TURN1,
        S_RDATA,
        S_TURN2,
        S_FINISH
    } acc_state_e;

endpackage

// File: rtl/ulpi_regacc_cmd.sv
`timescale 1ns/1ps
module ulpi_regacc_cmd
    import ulpi_regacc_pkg::*;
#(
    parameter int            AW       = 8,
    parameter logic [AW-1:0] EXT_BASE = AW'(8'h2F)
) (
    input  logic                wr,
    input  logic [AW-1:0]       addr,
    output logic [ULPI_DW-1:0]  cmd_byte,
    output logic                ext
);
    always_comb begin
        ext      = (addr >= EXT_BASE);
        cmd_byte = {(wr ? OP_REG_WRITE : OP_REG_READ),
                    (ext ? EXT_MARKER : addr[5:0])};
    end
endmodule

// File: rtl/ulpi_regacc_wdog.sv
`timescale 1ns/1ps
module ulpi_regacc_wdog #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic [TO_W-1:0] limit,
    output logic            expire
);
    logic [TO_W-1:0] cnt_q;

    assign expire = active && (cnt_q == (limit - TO_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TO_W'(1);
        end
    end

    // R9: the count never passes the limit while a transaction runs
    a_r9_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $stable(limit) && limit != '0) |-> (cnt_q < limit));
endmodule

// File: rtl/ulpi_regacc_engine.sv
`timescale 1ns/1ps
module ulpi_regacc_engine
    import ulpi_regacc_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            TO_W     = 16,
    parameter logic [AW-1:0] EXT_BASE = AW'(8'h2F)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_start,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [ULPI_DW-1:0]  req_wdata,
    input  logic [TO_W-1:0]     wd_limit,
    output logic [ULPI_DW-1:0]  rd_data,
    output logic                acc_done,
    output logic                acc_err,
    input  logic                ulpi_dir,
    input  logic                ulpi_nxt,
    input  logic [ULPI_DW-1:0]  ulpi_din,
    output logic [ULPI_DW-1:0]  ulpi_dout,
    output logic                ulpi_dout_en,
    output logic                ulpi_stp
);
    acc_state_e          state_q, state_d;
    logic                wr_q;
    logic [AW-1:0]       addr_q;
    logic [ULPI_DW-1:0]  wdata_q, rdata_q;
    logic                done_q, err_q;
    logic [ULPI_DW-1:0]  cmd_byte;
    logic                ext_acc;
    logic                wd_expire;
    logic                active;
    logic                accept;
    logic                drive;

    assign active = (state_q != S_IDLE);
    assign accept = req_start && !active;

    ulpi_regacc_cmd #(.AW(AW), .EXT_BASE(EXT_BASE)) i_cmd (
        .wr       (wr_q),
        .addr     (addr_q),
        .cmd_byte (cmd_byte),
        .ext      (ext_acc)
    );

    ulpi_regacc_wdog #(.TO_W(TO_W)) i_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .limit  (wd_limit),
        .expire (wd_expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_LOAD;
            S_LOAD:   if (!ulpi_dir) state_d = S_CMD;
            S_CMD: begin
                if (ulpi_dir)            state_d = S_LOAD;
                else if (ulpi_nxt) begin
                    if (ext_acc)         state_d = S_EADDR;
                    else if (wr_q)       state_d = S_WDATA;
                    else                 state_d = S_TURN1;
                end
            end
            S_EADDR:  if (ulpi_nxt) state_d = wr_q ? S_WDATA : S_TURN1;
            S_WDATA:  if (ulpi_nxt) state_d = S_STOP;
            S_STOP:   state_d = S_FINISH;
            S_TURN1:  if (ulpi_dir) state_d = S_RDATA;
            S_RDATA:  state_d = S_TURN2;
            S_TURN2:  state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
        if (wd_expire) state_d = S_IDLE;
    end

    // bus outputs decoded from state
    always_comb begin
        drive     = 1'b0;
        ulpi_dout = '0;
        ulpi_stp  = 1'b0;
        unique case (state_q)
            S_CMD:   begin drive = 1'b1; ulpi_dout = cmd_byte; end
            S_EADDR: begin drive = 1'b1; ulpi_dout = ULPI_DW'(addr_q); end
            S_WDATA: begin drive = 1'b1; ulpi_dout = wdata_q; end
            S_STOP:  begin drive = 1'b1; ulpi_stp = 1'b1; end
            default: ;
        endcase
        ulpi_dout_en = drive && !ulpi_dir;
    end

    // request capture, completion and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                done_q  <= 1'b0;
                err_q   <= 1'b0;
            end else if (state_q == S_FINISH) begin
                done_q  <= 1'b1;
            end else if (wd_expire) begin
                done_q  <= 1'b1;
                err_q   <= 1'b1;
            end
            if (state_q == S_RDATA) rdata_q <= ulpi_din;
        end
    end

    assign rd_data  = rdata_q;
    assign acc_done = done_q;
    assign acc_err  = err_q;

    // R7: a byte not yet taken stays on the bus
    a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (ulpi_dout_en && !ulpi_nxt && !ulpi_stp && !wd_expire) |=> $stable(ulpi_dout));
    // R3: stop lasts a single cycle
    a_r3_stp_single: assert property (@(posedge clk) disable iff (!rst_n)
        ulpi_stp |=> !ulpi_stp);
    // R9: an error is only ever reported together with done
    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> acc_done);
    // R11: accepting a request clears both flags
    a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!acc_done && !acc_err));
    // R9: watchdog expiry ends the transaction with an error
    a_r9_expire_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expire && state_q != S_FINISH) |=> (acc_done && acc_err && !active));
endmodule

// File: tb/test_ulpi_regacc_engine.sv
`timescale 1ns/1ps
module test_ulpi_regacc_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_start = 1'b0;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [15:0] wd_limit = 16'd200;
    logic [7:0] rd_data;
    logic       acc_done, acc_err;
    logic       ulpi_dir, ulpi_nxt;
    logic [7:0] ulpi_din;
    logic [7:0] ulpi_dout;
    logic       ulpi_dout_en, ulpi_stp;

    logic       nxt_en = 1'b1;
    logic       rx_dir = 1'b0;
    logic       phy_dir;
    logic [7:0] phy_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ulpi_regacc_engine i_ulpi_regacc_engine (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wd_limit(wd_limit),
        .rd_data(rd_data), .acc_done(acc_done), .acc_err(acc_err),
        .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_din(ulpi_din),
        .ulpi_dout(ulpi_dout), .ulpi_dout_en(ulpi_dout_en), .ulpi_stp(ulpi_stp)
    );

    // PHY model: takes bytes with NXT, stores writes, returns reads
    assign ulpi_nxt = nxt_en & ulpi_dout_en & ~ulpi_stp;
    assign ulpi_dir = phy_dir | rx_dir;
    assign ulpi_din = phy_data;

    logic [7:0] phy_regs [256];
    logic [7:0] last_cmd, last_ext, p_addr, p_wdata;
    logic       p_wr;
    int         p_stage, rd_phase;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) phy_regs[i] <= 8'(i) ^ 8'h5A;
            phy_dir <= 1'b0; phy_data <= '0; p_stage <= 0; rd_phase <= 0;
            last_cmd <= '0; last_ext <= '0; p_addr <= '0; p_wdata <= '0; p_wr <= 1'b0;
        end else begin
            case (rd_phase)
                1: begin phy_dir <= 1'b1; rd_phase <= 2; end
                2: begin phy_data <= phy_regs[p_addr]; rd_phase <= 3; end
                3: begin phy_dir <= 1'b0; phy_data <= '0; rd_phase <= 0; end
                default: ;
            endcase
            if (ulpi_dout_en && ulpi_nxt) begin
                case (p_stage)
                    0: begin
                        last_cmd <= ulpi_dout;
                        p_wr <= (ulpi_dout[7:6] == 2'b10);
                        if (ulpi_dout[5:0] == 6'h2F) p_stage <= 1;
                        else begin
                            p_addr <= {2'b00, ulpi_dout[5:0]};
                            if (ulpi_dout[7:6] == 2'b10) p_stage <= 2;
                            else rd_phase <= 1;
                        end
                    end
                    1: begin
                        last_ext <= ulpi_dout; p_addr <= ulpi_dout;
                        if (p_wr) p_stage <= 2;
                        else begin p_stage <= 0; rd_phase <= 1; end
                    end
                    2: begin p_wdata <= ulpi_dout; p_stage <= 3; end
                    default: ;
                endcase
            end
            if (ulpi_stp && p_stage == 3) begin
                phy_regs[p_addr] <= p_wdata;
                p_stage <= 0;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic start_req(input bit wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_start = 1'b0;
    endtask

    // reference model for a PHY that answers at once, compared every cycle
    task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d,
                          input int poke_k);
        bit    ext;
        int    n;
        string tg;
        ext = (a >= 8'h2F);
        n = 5 + (ext ? 1 : 0) + (wr ? 0 : 1);
        tg = wr ? (ext ? "R4" : "R3") : (ext ? "R6" : "R5");
        start_req(wr, a, d);
        for (int k = 0; k <= n; k++) begin
            if (k > 0) tick();
            if (k == poke_k + 1) req_start = 1'b0;
            chk(tg, "done", acc_done, (k >= n));
            chk("R11", "err", acc_err, 0);
            chk(tg, "drive", ulpi_dout_en,
                wr ? (k >= 1 && k <= n - 2) : (k >= 1 && k <= 1 + int'(ext)));
            chk(tg, "stp", ulpi_stp, (wr && k == n - 2));
            if (k == poke_k) begin
                req_start = 1'b1; req_write = 1'b1; req_addr = 8'h21; req_wdata = 8'h99;
            end
        end
        if (wr) chk(tg, "phy reg", phy_regs[a], d);
        else    chk(tg, "rd_data", rd_data, phy_regs[a]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "done", acc_done, 0);
        chk("R1", "err", acc_err, 0);
        chk("R1", "stp", ulpi_stp, 0);
        chk("R1", "drive", ulpi_dout_en, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) tick();

        // immediate and extended, below and at the threshold
        access(1'b1, 8'h15, 8'hC3, -1);
        chk("R2", "write cmd", last_cmd, 8'h95);
        access(1'b0, 8'h15, 8'h00, -1);
        chk("R2", "read cmd", last_cmd, 8'hD5);
        access(1'b1, 8'h2E, 8'h00, -1);
        chk("R2", "cmd below threshold", last_cmd, 8'hAE);
        access(1'b1, 8'h2F, 8'hFF, -1);
        chk("R2", "ext marker", last_cmd, 8'hAF);
        chk("R2", "ext addr", last_ext, 8'h2F);
        access(1'b1, 8'h40, 8'h6B, -1);
        chk("R2", "ext addr", last_ext, 8'h40);
        access(1'b0, 8'h2E, 8'h00, -1);
        chk("R5", "read back 00", rd_data, 8'h00);
        access(1'b0, 8'h2F, 8'h00, -1);
        chk("R6", "read back FF", rd_data, 8'hFF);
        access(1'b0, 8'hFF, 8'h00, -1);
        chk("R2", "ext read marker", last_cmd, 8'hEF);
        chk("R6", "untouched reg", rd_data, 8'hA5);

        // R11: done holds until the next start
        repeat (3) tick();
        chk("R11", "done held", acc_done, 1);

        // R10: start while busy is ignored
        access(1'b1, 8'h20, 8'h11, 2);
        repeat (2) tick();
        chk("R10", "ignored addr", phy_regs[8'h21], 8'h21 ^ 8'h5A);
        access(1'b0, 8'h21, 8'h00, -1);
        chk("R10", "ignored read", rd_data, 8'h7B);

        // R7: NXT stall on the data byte
        start_req(1'b1, 8'h05, 8'hA7);
        tick();
        tick(); nxt_en = 1'b0;
        chk("R7", "hold k2", ulpi_dout, 8'hA7);
        tick();
        chk("R7", "hold k3", ulpi_dout, 8'hA7);
        chk("R7", "done k3", acc_done, 0);
        tick(); nxt_en = 1'b1;
        chk("R7", "hold k4", ulpi_dout, 8'hA7);
        tick();
        chk("R7", "stp k5", ulpi_stp, 1);
        tick();
        chk("R7", "done k6", acc_done, 0);
        tick();
        chk("R7", "done k7", acc_done, 1);
        chk("R7", "phy reg", phy_regs[8'h05], 8'hA7);

        // R8: DIR before command acceptance
        nxt_en = 1'b0;
        start_req(1'b1, 8'h10, 8'h3C);
        tick();
        chk("R8", "cmd driven", ulpi_dout_en, 1);
        @(negedge clk); rx_dir = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R8", "bus released", ulpi_dout_en, 0);
            chk("R8", "not done", acc_done, 0);
        end
        @(negedge clk); rx_dir = 1'b0; nxt_en = 1'b1;
        for (int i = 0; i < 20 && !acc_done; i++) tick();
        chk("R8", "done", acc_done, 1);
        chk("R8", "err", acc_err, 0);
        chk("R8", "phy reg", phy_regs[8'h10], 8'h3C);
        chk("R8", "cmd", last_cmd, 8'h90);

        // R9: watchdog on a silent PHY
        wd_limit = 16'd12; nxt_en = 1'b0;
        start_req(1'b1, 8'h07, 8'h55);
        for (int k = 1; k <= 11; k++) tick();
        chk("R9", "done k11", acc_done, 0);
        tick();
        chk("R9", "done k12", acc_done, 1);
        chk("R9", "err k12", acc_err, 1);
        chk("R9", "no write", phy_regs[8'h07], 8'h07 ^ 8'h5A);
        wd_limit = 16'd200; nxt_en = 1'b1;
        repeat (2) tick();
        access(1'b1, 8'h07, 8'h55, -1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule